// File: doc/BRIEF.md
# Drift Alarm Service Request and Poll Responder

This block watches two out-of-range flags from a window comparator, one for each direction of drift. A rising edge on either flag fires a fixed-width one-shot. The one-shot sets a request latch, and the latch pulls an active-low service request line that is shared with other devices. A bus master that sees the request runs a poll to find out which device raised it. While a request is pending and the master holds both its poll strobe and its selected address bit high, the block answers by enabling a drive-low on one data bus line.

The master then confirms by driving that address bit low while it holds the same data line low itself. That falling edge clears the latch. Clearing the latch releases the request line and closes the poll response path. The two drift flags can also be read at any time as status bits.

All asynchronous inputs pass through a two-stage synchronizer. The width of the one-shot is set by a cycle count parameter. At a 1 MHz clock, the default of 35 cycles gives a 35 µs stretch.

Top module: `srq_poll_responder`

## Requirements
- R1: A rising edge of (up OR down) asserts srq_n_o low exactly 3 clock edges after the input changes: 2 edges of synchronization and 1 edge of register.
- R2: For PULSE_CYCLES cycles after a trigger, the request is held set. An acknowledge that arrives in that window has no effect, and srq_n_o stays low.
- R3: While a request is pending, poll_i high together with addr7_i high makes data_pull_o equal 8'h04, which enables a drive-low on bit 2 only. This happens 3 edges after the inputs settle.
- R4: While no request is pending, a poll (poll_i and addr7_i high) leaves data_pull_o at 8'h00.
- R5: Once the pulse has ended, a falling edge on addr7_i with data_i[2] low clears the request. srq_n_o returns high, and data_pull_o returns to 8'h00.
- R6: A falling edge on addr7_i while data_i[2] is high does not clear the request.
- R7: An edge on up or down while a request is already latched keeps the request set and queues nothing. A single acknowledge after the pulse leaves srq_n_o high for good.
- R8: status_o[0] reflects up_i and status_o[1] reflects down_i, each after the 2-stage synchronizer.
- R9: While rst_n is low, srq_n_o is high, data_pull_o is 8'h00 and status_o is 2'b00, whatever the request state was.
- R10: data_pull_o never has any bit other than bit 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Comparator flag: drift past upper limit |
| down_i | input | 1 | Comparator flag: drift past lower limit |
| poll_i | input | 1 | Master poll strobe |
| addr7_i | input | 1 | Poll-select and acknowledge address bit |
| data_i | input | 8 | Data bus levels as seen on the bus |
| srq_n_o | output | 1 | Service request, active low (open-drain enable) |
| data_pull_o | output | 8 | Per-line drive-low enables for the data bus |
| status_o | output | 2 | Synchronized {down, up} flags |

## Verification
The state of the request latch can be seen directly on srq_n_o one register after it changes. A latch that is stuck, set late or cleared at the wrong time therefore shows up within a cycle of the expected edge. A one-shot that is too short lets an early acknowledge clear the request inside the pulse window, so srq_n_o rises when it should stay low. A wrong falling-edge detector shows up as a clear with D2 high, or as no clear at all. A wrong poll gate shows a pull enable on an idle block, or on a line other than bit 2, 3 edges after the poll.

// File: rtl/srq_pkg.sv
package srq_pkg;

    typedef struct packed {
        logic req;
        logic pull;
        logic lvl_prev;
        logic a7_prev;
    } srq_ctl_t;

    typedef struct packed {
        logic active;
        logic [15:0] cnt;
    } os_state_t;

endpackage

// File: rtl/srq_sync.sv
module srq_sync #(
    parameter int WIDTH  = 5,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/srq_oneshot.sv
module srq_oneshot
    import srq_pkg::*;
#(
    parameter int PULSE_CYCLES = 35
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic active_o
);
    localparam logic [15:0] LOAD = 16'(PULSE_CYCLES - 1);

    os_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.active) begin
            if (st_q.cnt == '0) st_d.active = 1'b0;
            else                st_d.cnt    = st_q.cnt - 16'd1;
        end else if (trig_i) begin
            st_d.active = 1'b1;
            st_d.cnt    = LOAD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;

    // Pulse ends one cycle after the counter is exhausted; no retrigger inside it.
    assert_pulse_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && st_q.cnt == '0) |=> !st_q.active);
    assert_pulse_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.active) |-> (st_q.cnt == LOAD));
endmodule

// File: rtl/srq_poll_responder.sv
module srq_poll_responder
    import srq_pkg::*;
#(
    parameter int PULSE_CYCLES = 35,
    parameter int SYNC_STAGES  = 2,
    parameter int DATA_W       = 8,
    parameter int RESP_BIT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_i,
    input  logic              down_i,
    input  logic              poll_i,
    input  logic              addr7_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              srq_n_o,
    output logic [DATA_W-1:0] data_pull_o,
    output logic [1:0]        status_o
);
    localparam int SW = 5;

    logic [SW-1:0] raw_in, syn;
    logic s_up, s_dn, s_poll, s_a7, s_resp;
    logic trig, ack, os_active;
    srq_ctl_t ctl_d, ctl_q;

    assign raw_in = {data_i[RESP_BIT], addr7_i, poll_i, down_i, up_i};

    srq_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    assign {s_resp, s_a7, s_poll, s_dn, s_up} = syn;

    // Rising edge of the combined drift level.
    assign trig = (s_up | s_dn) & ~ctl_q.lvl_prev;
    // Falling address bit while the master holds the answer line low.
    assign ack  = ctl_q.a7_prev & ~s_a7 & ~s_resp;

    srq_oneshot #(.PULSE_CYCLES(PULSE_CYCLES)) u_oneshot (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig_i   (trig),
        .active_o (os_active)
    );

    always_comb begin
        ctl_d          = ctl_q;
        ctl_d.lvl_prev = s_up | s_dn;
        ctl_d.a7_prev  = s_a7;
        if (trig || os_active) ctl_d.req = 1'b1;
        else if (ack)          ctl_d.req = 1'b0;
        ctl_d.pull = ctl_q.req & s_poll & s_a7;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign srq_n_o  = ~ctl_q.req;
    assign status_o = {s_dn, s_up};

    for (genvar b = 0; b < DATA_W; b++) begin : g_pull
        if (b == RESP_BIT) begin : g_resp
            assign data_pull_o[b] = ctl_q.pull;
        end else begin : g_idle
            assign data_pull_o[b] = 1'b0;
        end
    end

    // A running pulse always leaves the request asserted on the next edge.
    assert_req_during_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        os_active |=> !srq_n_o);
    // The request can only drop once the pulse is over.
    assert_clear_after_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srq_n_o) |-> $past(!os_active));
    // A poll answer implies a pending request on the previous edge.
    assert_no_idle_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        data_pull_o[RESP_BIT] |-> $past(!srq_n_o));
    // In reset the block is idle at its ports.
    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |-> (srq_n_o && data_pull_o == '0));
endmodule

// File: tb/srq_poll_responder_test.sv
module srq_poll_responder_test;
    localparam int CLK_PERIOD = 10;
    localparam int P = 35;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_i = 0, down_i = 0, poll_i = 0, addr7_i = 0;
    logic [7:0] data_i = 8'hFF;
    logic srq_n_o;
    logic [7:0] data_pull_o;
    logic [1:0] status_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    srq_poll_responder #(.PULSE_CYCLES(P)) uut (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .down_i(down_i),
        .poll_i(poll_i), .addr7_i(addr7_i), .data_i(data_i),
        .srq_n_o(srq_n_o), .data_pull_o(data_pull_o), .status_o(status_o)
    );

    typedef struct packed {
        logic       up;
        logic       dn;
        logic       poll;
        logic       a7;
        logic       d2;
        logic [7:0] wait_n;
        logic       exp_srq_n;
        logic [7:0] exp_pull;
        logic [1:0] exp_st;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,1, 8'd4,  1, 8'h00, 2'b00}, // idle
        '{0,0,1,1,1, 8'd4,  1, 8'h00, 2'b00}, // R4 poll while idle
        '{0,0,0,0,1, 8'd4,  1, 8'h00, 2'b00},
        '{1,0,0,0,1, 8'd4,  0, 8'h00, 2'b01}, // R1 up rises, R8
        '{1,0,0,0,1, 8'd40, 0, 8'h00, 2'b01}, // held past pulse
        '{0,1,0,0,1, 8'd4,  0, 8'h00, 2'b10}, // R8 down
        '{0,1,1,1,1, 8'd4,  0, 8'h04, 2'b10}, // R3 poll answer
        '{0,1,1,1,0, 8'd4,  0, 8'h04, 2'b10}, // master holds D2 low
        '{0,1,1,0,0, 8'd4,  1, 8'h00, 2'b10}, // R5 ack
        '{0,0,0,0,1, 8'd4,  1, 8'h00, 2'b00},
        '{0,1,0,0,1, 8'd40, 0, 8'h00, 2'b10}, // down rises, pulse done
        '{0,1,1,1,1, 8'd4,  0, 8'h04, 2'b10}, // R3
        '{0,1,1,0,1, 8'd4,  0, 8'h00, 2'b10}, // R6 fall with D2 high
        '{0,1,0,0,1, 8'd4,  0, 8'h00, 2'b10}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ack_seq(input logic d2_low);
        poll_i = 1; addr7_i = 1; data_i[2] = 1'b1;
        settle(4);
        data_i[2] = ~d2_low;
        settle(2);
        addr7_i = 0;
        settle(4);
        poll_i = 0; data_i[2] = 1'b1;
        settle(2);
    endtask

    initial begin
        while (1) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                $display("FAIL watchdog: actual=%0d expected<=20000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks + 1);
                $finish;
            end
        end
    end

    initial begin
        settle(3);
        // R9 reset state
        check("R9 srq in reset", srq_n_o, 1);
        check("R9 pull in reset", data_pull_o, 8'h00);
        check("R9 status in reset", status_o, 2'b00);
        rst_n = 1;
        settle(2);

        for (int i = 0; i < NV; i++) begin
            up_i = VECS[i].up; down_i = VECS[i].dn;
            poll_i = VECS[i].poll; addr7_i = VECS[i].a7;
            data_i[2] = VECS[i].d2;
            settle(int'(VECS[i].wait_n));
            check($sformatf("R1/R5/R6 srq vec %0d", i), srq_n_o, VECS[i].exp_srq_n);
            check($sformatf("R3/R4/R10 pull vec %0d", i), data_pull_o, VECS[i].exp_pull);
            check($sformatf("R8 status vec %0d", i), status_o, VECS[i].exp_st);
        end

        // R9: reset with a request pending
        rst_n = 0;
        settle(2);
        check("R9 srq released by reset", srq_n_o, 1);
        check("R9 pull cleared by reset", data_pull_o, 8'h00);
        down_i = 0;
        rst_n = 1;
        settle(4);

        // R1 exact latency
        up_i = 1;
        settle(2);
        check("R1 srq before 3rd edge", srq_n_o, 1);
        settle(1);
        check("R1 srq at 3rd edge", srq_n_o, 0);

        // R2 ack inside pulse window is ignored
        ack_seq(1'b1);
        check("R2 ack during pulse ignored", srq_n_o, 0);
        up_i = 0;
        settle(P + 5);
        ack_seq(1'b1);
        check("R5 ack after pulse clears", srq_n_o, 1);
        check("R5 pull released", data_pull_o, 8'h00);

        // R7 second edge while latched queues nothing
        up_i = 1;
        settle(P + 5);
        up_i = 0;
        settle(4);
        down_i = 1;
        settle(P + 5);
        check("R7 still latched", srq_n_o, 0);
        ack_seq(1'b1);
        check("R7 single ack clears", srq_n_o, 1);
        settle(10);
        check("R7 nothing queued", srq_n_o, 1);
        check("R10 only bit 2 ever", data_pull_o & 8'hFB, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule